// File: doc/BRIEF.md
# MII Management Frame Controller

This block runs clause-22 management transactions towards an Ethernet PHY. The host puts a complete, pre-encoded 32-bit frame into the data register. The write starts a transaction. The controller generates MDC from the system clock and sends 32 preamble ones. It then shifts the command word out on MDIO, most significant bit first. On a read it releases the line and collects the sixteen data bits that the PHY returns.

When the frame ends, a read result is put into the low half of the data register. A sticky completion flag is then raised, and it stays set until the host writes a one to its position in the event word. MDC runs only while a transaction is in progress. A programmable half-period count sets its rate, so the host chooses a value that keeps MDC at or below 2.5 MHz. MDIO is presented as a separate value and enable pair for an external tri-state pad.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A transaction is 64 MDC cycles long. It consists of 32 ones followed by the command word, sent MSB first. In the command word, bits 31:30 hold the start code 01 and bits 29:28 hold the opcode (10 read, 01 write). Bits 27:23 hold the PHY address, bits 22:18 the register address, bits 17:16 the turnaround 10, and bits 15:0 the write data.
- R2: While a transaction runs, each MDC phase lasts exactly `speed` system clock cycles, so the MDC period is 2*speed cycles. MDC is low whenever the controller is idle.
- R3: MDIO output changes only where MDC falls. The input is sampled where MDC rises.
- R4: For a read, the output enable drops from frame bit 47 onward, which is the second turnaround bit (command bit 16), and stays low to the end of the frame. For a write, the output enable is high for all 64 bits. It is low while the controller is idle.
- R5: After a read, data register bits 15:0 hold the 16 bits sampled in frame bits 48..63, first bit in bit 15. Bits 31:16 keep the command. After a write, the register keeps the command word.
- R6: Completion sets the event flag, which sits at bit 23 of the event word. An event write with bit 23 set clears the flag. Event writes with bit 23 clear have no effect on it.
- R7: A data register write while idle loads the register and starts a transaction. A data register write while busy is ignored.
- R8: While the speed value is zero, MDC does not toggle and a pending transaction does not advance. It proceeds once a nonzero speed is written.
- R9: After reset: busy low, MDC low, output enable low, event flag clear, data register zero, speed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the data register |
| cmd_wdata | input | 32 | Command word to load |
| spd_wr | input | 1 | Write strobe for the speed value |
| spd_wdata | input | SPD_W | MDC half-period count in system cycles |
| evt_wr | input | 1 | Write strobe for the event word |
| evt_wdata | input | 32 | Event write data, a one in bit 23 clears the flag |
| data_q | output | 32 | Data register contents |
| mgmt_evt | output | 1 | Completion event flag |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A sweep crosses speed values 1 to 4 with read and write frames that carry different PHY addresses, register addresses and data patterns. Every MDC rising edge is captured, so frame content, enable timing and the MDC period are all compared bit by bit. Reads and writes at the same speed separate the turnaround release from a fully driven frame. The differing speeds separate a correct half-period count from an off-by-one divider. Separate patterns cover a zero speed that holds a pending frame, a second command issued mid-frame, and event writes with and without bit 23 set.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants for the management frame controller.
// Assumes a fixed 32-bit command word and a 32-bit preamble.
package mdio_mgmt_pkg;
    localparam int CMD_W     = 32;
    localparam int PRE_BITS  = 32;
    localparam int FRAME_LEN = PRE_BITS + CMD_W;
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);
    localparam int RD_W      = 16;
    localparam int TA2_POS   = FRAME_LEN - RD_W - 1;
    localparam int RD_FIRST  = FRAME_LEN - RD_W;
    localparam int EVT_BIT   = 23;
    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
// MDC generator: toggles MDC every `spd` system cycles while run is high.
// Assumes spd may change at any time; a zero value freezes MDC in place.
// MDC is forced low whenever run is low.
module mdio_mgmt_clkdiv #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] spd,
    output logic             mdc,
    output logic             rise_tk,
    output logic             fall_tk
);
    logic [SPD_W-1:0] cnt;
    logic             wrap;

    // Phase end reached when the count covers the programmed half period.
    always_comb begin
        wrap    = run && (spd != '0) && ({1'b0, cnt} + 1'b1 >= {1'b0, spd});
        rise_tk = wrap && !mdc;
        fall_tk = wrap && mdc;
    end

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (spd == '0) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_mgmt_shifter.sv
// Frame sequencer: sends preamble plus command on MDIO and collects read data.
// Assumes cmd is held stable for the whole transaction and that rise/fall
// ticks alternate, beginning with a rise, starting from MDC low.
module mdio_mgmt_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             rise_tk,
    input  logic             fall_tk,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done_tk,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [RD_W-1:0]  rx_data
);
    logic [IDX_W-1:0] idx;
    logic             is_rd;
    logic [6:0]       pos;
    logic             nxt_bit;

    // Select the frame bit for the current index: preamble, then command MSB first.
    always_comb begin
        is_rd   = (cmd[CMD_W-3:CMD_W-4] == OP_READ);
        pos     = 7'(FRAME_LEN - 1) - 7'(idx);
        nxt_bit = (int'(idx) < PRE_BITS) ? 1'b1 : cmd[pos[4:0]];
        done_tk = busy && fall_tk && (int'(idx) == FRAME_LEN);
    end

    // Bit sequencing: advance and sample on rise, drive on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rx_data <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                idx     <= '0;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end
        end else begin
            if (rise_tk) begin
                idx <= idx + 1'b1;
                if (is_rd && int'(idx) >= RD_FIRST)
                    rx_data <= {rx_data[RD_W-2:0], mdio_i};
            end
            if (fall_tk) begin
                if (done_tk) begin
                    busy    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    mdio_o  <= nxt_bit;
                    mdio_oe <= !(is_rd && int'(idx) >= TA2_POS);
                end
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top of the management frame controller: data, speed and event registers,
// with the divider and the frame sequencer below.
// Assumes the host issues one register write per cycle at most per strobe.
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_wdata,
    input  logic             spd_wr,
    input  logic [SPD_W-1:0] spd_wdata,
    input  logic             evt_wr,
    input  logic [31:0]      evt_wdata,
    output logic [31:0]      data_q,
    output logic             mgmt_evt,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [SPD_W-1:0] spd_q;
    logic             rise_tk, fall_tk, done_tk, start;
    logic [RD_W-1:0]  rx_data;

    assign start = cmd_wr && !busy;

    // Speed register.
    always_ff @(posedge clk) begin
        if (!rst_n)      spd_q <= '0;
        else if (spd_wr) spd_q <= spd_wdata;
    end

    // Data register: loaded when idle, low half replaced by read result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (start)
            data_q <= cmd_wdata;
        else if (done_tk && data_q[CMD_W-3:CMD_W-4] == OP_READ)
            data_q[RD_W-1:0] <= rx_data;
    end

    // Completion flag: set wins over a simultaneous write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mgmt_evt <= 1'b0;
        else if (done_tk)
            mgmt_evt <= 1'b1;
        else if (evt_wr && evt_wdata[EVT_BIT])
            mgmt_evt <= 1'b0;
    end

    mdio_mgmt_clkdiv #(.SPD_W(SPD_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .spd     (spd_q),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    mdio_mgmt_shifter u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd     (data_q),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done_tk (done_tk),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rx_data (rx_data)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Protocol checker for the management frame controller, attached by bind.
// Assumes observation of the top ports plus the internal speed register.
module mdio_mgmt_chk #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [SPD_W-1:0] spd,
    input logic             mgmt_evt,
    input logic             evt_wr,
    input logic             evt_clr_bit,
    input logic             cmd_wr,
    input logic [31:0]      data_q
);
    a_r3_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> $fell(mdc));

    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r4_oe_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r4_release_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdio_oe) |-> (data_q[29:28] == 2'b10));

    a_r6_evt_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && evt_clr_bit && !busy) |=> !mgmt_evt);

    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(data_q[31:16]));

    a_r8_zero_speed_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (spd == '0) |=> $stable(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.SPD_W(SPD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .spd         (spd_q),
    .mgmt_evt    (mgmt_evt),
    .evt_wr      (evt_wr),
    .evt_clr_bit (evt_wdata[23]),
    .cmd_wr      (cmd_wr),
    .data_q      (data_q)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
// Bench with a behavioural PHY: captures every MDC rising edge, answers reads.
module mdio_mgmt_ctrl_bench;
    localparam int SPD_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [31:0]      cmd_wdata = '0;
    logic             spd_wr = 1'b0;
    logic [SPD_W-1:0] spd_wdata = '0;
    logic             evt_wr = 1'b0;
    logic [31:0]      evt_wdata = '0;
    logic [31:0]      data_q;
    logic             mgmt_evt, busy, mdc, mdio_o, mdio_oe;
    logic             mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ecnt = 0;
    int rise_t0 = 0;
    int rise_t1 = 0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_rdata = '0;

    mdio_mgmt_ctrl #(.SPD_W(SPD_W)) u_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .spd_wr(spd_wr), .spd_wdata(spd_wdata), .evt_wr(evt_wr),
        .evt_wdata(evt_wdata), .data_q(data_q), .mgmt_evt(mgmt_evt),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    // PHY model: record the frame at each MDC rise.
    always @(posedge mdc) begin
        if (ecnt < 64) begin
            cap_o[ecnt]  = mdio_o;
            cap_oe[ecnt] = mdio_oe;
        end
        if (ecnt == 0) rise_t0 = cyc;
        if (ecnt == 1) rise_t1 = cyc;
        ecnt++;
    end

    // PHY model: present the next read bit after each MDC fall.
    always @(negedge mdc) begin
        if (ecnt == 47)                    mdio_i = 1'b0;
        else if (ecnt >= 48 && ecnt < 64)  mdio_i = phy_rdata[63 - ecnt];
        else                               mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic set_speed(input int s);
        @(negedge clk); spd_wr = 1'b1; spd_wdata = SPD_W'(s);
        @(negedge clk); spd_wr = 1'b0;
    endtask

    task automatic host_cmd(input logic [31:0] w);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic evt_write(input logic [31:0] w);
        @(negedge clk); evt_wr = 1'b1; evt_wdata = w;
        @(negedge clk); evt_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
        if (busy) check(1'b0, "watchdog busy stuck", 64'(busy), 64'd0);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_cmd(input bit rd, input int phy, input int rg,
                                           input logic [15:0] wd);
        return {2'b01, (rd ? 2'b10 : 2'b01), 5'(phy), 5'(rg), 2'b10, wd};
    endfunction

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        logic [63:0] f;
        for (int i = 0; i < 64; i++) f[i] = (i < 32) ? 1'b1 : c[63 - i];
        return f;
    endfunction

    function automatic logic [63:0] exp_oe(input bit rd);
        logic [63:0] f;
        for (int i = 0; i < 64; i++) f[i] = !(rd && i >= 47);
        return f;
    endfunction

    // One full transaction with checks on frame, enable, period, result and event.
    task automatic run_txn(input int s, input bit rd, input int phy, input int rg,
                           input logic [15:0] wd, input logic [15:0] rdat);
        logic [31:0] c;
        logic [63:0] ef, eo, mask;
        c = mk_cmd(rd, phy, rg, wd);
        phy_rdata = rdat;
        set_speed(s);
        evt_write(32'h0080_0000);
        ecnt = 0;
        host_cmd(c);
        wait_idle();
        ef = exp_frame(c);
        eo = exp_oe(rd);
        mask = eo;
        check(ecnt == 64, "R1 edge count", 64'(ecnt), 64'd64);
        check((cap_o & mask) == (ef & mask), "R1 frame bits", cap_o & mask, ef & mask);
        check(cap_oe == eo, "R4 output enable", cap_oe, eo);
        check(rise_t1 - rise_t0 == 2 * s, "R2 mdc period", 64'(rise_t1 - rise_t0), 64'(2 * s));
        if (rd) check(data_q == {c[31:16], rdat}, "R5 read result", 64'(data_q), 64'({c[31:16], rdat}));
        else    check(data_q == c, "R5 write keeps cmd", 64'(data_q), 64'(c));
        check(mgmt_evt == 1'b1, "R6 event set", 64'(mgmt_evt), 64'd1);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R2 R4 idle lines", {mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        #(8 * 190000);
        check(1'b0, "watchdog timeout", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [31:0] c1;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check({busy, mdc, mdio_oe, mgmt_evt} == 4'b0, "R9 reset controls",
              {busy, mdc, mdio_oe, mgmt_evt}, 64'd0);
        check(data_q == 32'd0, "R9 reset data", 64'(data_q), 64'd0);

        // Sweep speeds, reads and writes (R1 R2 R3 R4 R5 R6)
        for (int s = 1; s <= 4; s++) begin
            run_txn(s, 1'b0, 5 * s + 1, 31 - s, 16'hA5C3 ^ 16'(s * 16'h1111), 16'h0000);
            run_txn(s, 1'b1, 31 - s, 3 * s, 16'h0000, 16'h8001 ^ 16'(s * 16'h0F0F));
        end
        run_txn(2, 1'b1, 0, 0, 16'h0000, 16'hFFFF);
        run_txn(3, 1'b0, 31, 31, 16'hFFFF, 16'h0000);

        // R6: event write without bit 23 has no effect, with bit 23 clears
        evt_write(32'hFF7F_FFFF);
        check(mgmt_evt == 1'b1, "R6 other bits ignored", 64'(mgmt_evt), 64'd1);
        evt_write(32'h0080_0000);
        check(mgmt_evt == 1'b0, "R6 write one clears", 64'(mgmt_evt), 64'd0);

        // R7: second command during a frame is ignored
        set_speed(3);
        ecnt = 0;
        c1 = mk_cmd(1'b0, 9, 4, 16'h1234);
        host_cmd(c1);
        repeat (20) @(negedge clk);
        host_cmd(mk_cmd(1'b1, 2, 7, 16'h0000));
        check(data_q == c1, "R7 busy write ignored", 64'(data_q), 64'(c1));
        wait_idle();
        check(cap_o == exp_frame(c1), "R7 frame of first cmd", cap_o, exp_frame(c1));
        check(ecnt == 64, "R7 single frame", 64'(ecnt), 64'd64);
        evt_write(32'h0080_0000);

        // R8: zero speed stalls a pending frame
        set_speed(0);
        ecnt = 0;
        c1 = mk_cmd(1'b0, 1, 2, 16'hBEEF);
        host_cmd(c1);
        repeat (100) @(negedge clk);
        e0 = ecnt;
        check(e0 == 0 && mdc == 1'b0, "R8 mdc stopped", 64'(e0), 64'd0);
        check(busy == 1'b1 && mgmt_evt == 1'b0, "R8 frame pending", {busy, mgmt_evt}, 64'b10);
        set_speed(2);
        wait_idle();
        check(ecnt == 64 && mgmt_evt == 1'b1, "R8 resumes", 64'(ecnt), 64'd64);
        check(cap_o == exp_frame(c1), "R8 frame after resume", cap_o, exp_frame(c1));

        finish_run();
    end
endmodule